// File: doc/BRIEF.md
# JTAG Test Access Port

This block is the test access port of a device under board test. A 16-state controller steps on the TMS level seen at each rising TCK edge. It moves serial data from TDI to TDO through a 3-bit instruction register, a one-bit bypass register or a boundary register chain of configurable length. TDO changes on the falling TCK edge. TDO is enabled only while a shift is in progress, and the block presents it as a data bit together with a separate output enable.

Toward the core, the block gives three mode signals decoded from the active instruction: drive the pins from the boundary register, hold the pins at the boundary values, or float all pins. It also provides the parallel side of the boundary register. One input vector is captured from the pins, and one output vector carries the latched values that the pad logic drives when a mode calls for it. TCK is meant to run at up to 20 MHz. Any board-level pattern generation and the pad buffers sit outside this block.

Top module: `jtag_tap`

## Requirements
- R1: TMS and TDI are sampled on the rising TCK edge, and the controller follows the standard 16-state sequence. Five rising edges with TMS high reach Test-Logic-Reset from any state, and reaching it sets the instruction to BYPASS (all modes low).
- R2: While trst_n is low, the block is reset at once, independent of TCK. The instruction becomes BYPASS, the three mode outputs and tdo_oe are 0, and bsr_drive is all zeros.
- R3: TDO changes only on the falling TCK edge. tdo_oe is 1 only while the controller is in Shift-IR or Shift-DR.
- R4: Capture-IR loads 3'b001, so the first three bits seen on TDO in Shift-IR are 1, 0, 0. Bits shift in and out least significant first.
- R5: The active instruction changes only on the falling TCK edge in Update-IR, or in Test-Logic-Reset. Shifting new bits does not change the mode outputs until Update-IR.
- R6: Code 000 drives mode_extest high and selects the boundary chain as the data register.
- R7: Code 001 leaves all mode outputs low and selects the boundary chain, so the pins are captured and values can be preloaded.
- R8: Code 101 drives mode_highz high and selects the bypass register.
- R9: Code 110 drives mode_clamp high, selects the bypass register, and leaves bsr_drive unchanged through Update-DR.
- R10: Code 111 and the unassigned codes 010, 011 and 100 select the bypass register with no mode output high. Capture-DR loads 0 into the bypass register, which then delays TDI by one shift.
- R11: When the boundary chain is selected, Capture-DR loads pin_in. Cell 0 lies next to TDO, and new bits enter at cell BSR_LEN-1. bsr_drive takes the shifted contents on the falling edge in Update-DR only under codes 000 and 001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO, high only during a shift |
| pin_in | input | BSR_LEN | Pin levels captured into the boundary chain |
| bsr_drive | output | BSR_LEN | Latched boundary values for the pad logic |
| mode_extest | output | 1 | Pins take their values from bsr_drive |
| mode_clamp | output | 1 | Pins held at bsr_drive while bypass is scanned |
| mode_highz | output | 1 | All device pins floated |

## Verification
A controller state that is off by one shows within one TCK cycle. tdo_oe opens or closes on the wrong falling edge, or the captured IR pattern appears shifted by one bit. A wrong instruction decode shows at the mode outputs right after Update-IR. It also shows one DR scan later as a chain length of 1 where BSR_LEN was expected, or the reverse. A boundary update register written under the wrong instruction shows at bsr_drive on the falling edge in Update-DR.

// File: rtl/jtag_pkg.sv
package jtag_pkg;
  typedef enum logic [3:0] {
    ST_RESET  = 4'hF, ST_IDLE   = 4'hC,
    ST_SELDR  = 4'h7, ST_CAPDR  = 4'h6, ST_SHDR  = 4'h2, ST_EX1DR = 4'h1,
    ST_PAUDR  = 4'h3, ST_EX2DR  = 4'h0, ST_UPDDR = 4'h5,
    ST_SELIR  = 4'h4, ST_CAPIR  = 4'hE, ST_SHIR  = 4'hA, ST_EX1IR = 4'h9,
    ST_PAUIR  = 4'hB, ST_EX2IR  = 4'h8, ST_UPDIR = 4'hD
  } tap_state_t;

  localparam int unsigned IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b001;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 3'b101;
  localparam logic [IR_W-1:0] OP_CLAMP  = 3'b110;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE_VAL = 3'b001;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET: state_d = tms ? ST_RESET : ST_IDLE;
      ST_IDLE:  state_d = tms ? ST_SELDR : ST_IDLE;
      ST_SELDR: state_d = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: state_d = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  state_d = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: state_d = tms ? ST_UPDDR : ST_PAUDR;
      ST_PAUDR: state_d = tms ? ST_EX2DR : ST_PAUDR;
      ST_EX2DR: state_d = tms ? ST_UPDDR : ST_SHDR;
      ST_UPDDR: state_d = tms ? ST_SELDR : ST_IDLE;
      ST_SELIR: state_d = tms ? ST_RESET : ST_CAPIR;
      ST_CAPIR: state_d = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  state_d = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: state_d = tms ? ST_UPDIR : ST_PAUIR;
      ST_PAUIR: state_d = tms ? ST_EX2IR : ST_PAUIR;
      ST_EX2IR: state_d = tms ? ST_UPDIR : ST_SHIR;
      ST_UPDIR: state_d = tms ? ST_SELDR : ST_IDLE;
      default:  state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  assign state = state_q;

  // R1
  tlr_reach_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state_q == ST_RESET));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_t      state,
  output logic            ir_so,
  output logic [IR_W-1:0] ir_code
);
  logic [IR_W-1:0] sh_q, sh_d;
  logic            sh_en;
  logic [IR_W-1:0] act_q;

  assign sh_en = (state == ST_CAPIR) || (state == ST_SHIR);

  always_comb begin
    sh_d = sh_q;
    if (state == ST_CAPIR)     sh_d = IR_CAPTURE_VAL;
    else if (state == ST_SHIR) sh_d = {tdi, sh_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)    sh_q <= OP_BYPASS;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                 act_q <= OP_BYPASS;
    else if (state == ST_RESET)  act_q <= OP_BYPASS;
    else if (state == ST_UPDIR)  act_q <= sh_q;
  end

  assign ir_so   = sh_q[0];
  assign ir_code = act_q;

  // R4
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAPIR) |=> (sh_q[1:0] == 2'b01));

  // R5
  ir_update_only_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(act_q) |-> (state == ST_UPDIR || state == ST_RESET));
endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
  import jtag_pkg::*;
#(
  parameter int unsigned LEN = 8
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           tdi,
  input  logic           sel,
  input  tap_state_t     state,
  input  logic [LEN-1:0] pin_in,
  output logic           so,
  output logic [LEN-1:0] drive
);
  localparam int unsigned LAST = LEN - 1;

  logic [LEN-1:0] sh_q, sh_d, upd_q;
  logic           cap_en, shift_en, upd_en;

  assign cap_en   = sel && (state == ST_CAPDR);
  assign shift_en = sel && (state == ST_SHDR);
  assign upd_en   = sel && (state == ST_UPDDR);

  for (genvar g = 0; g < LEN; g++) begin : g_cell
    logic from_prev;
    if (g == LAST) begin : g_head
      assign from_prev = tdi;
    end else begin : g_body
      assign from_prev = sh_q[g+1];
    end
    always_comb begin
      sh_d[g] = sh_q[g];
      if (cap_en)        sh_d[g] = pin_in[g];
      else if (shift_en) sh_d[g] = from_prev;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 sh_q <= '0;
    else if (cap_en || shift_en) sh_q <= sh_d;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     upd_q <= '0;
    else if (upd_en) upd_q <= sh_q;
  end

  assign so    = sh_q[0];
  assign drive = upd_q;

  // R11
  bsr_update_gate_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(upd_q) |-> (sel && state == ST_UPDDR));

  // R11
  bsr_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (sel && state == ST_CAPDR) |=> (sh_q == $past(pin_in)));
endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
  import jtag_pkg::*;
#(
  parameter int unsigned BSR_LEN = 8
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] bsr_drive,
  output logic               mode_extest,
  output logic               mode_clamp,
  output logic               mode_highz
);
  tap_state_t      state;
  logic [IR_W-1:0] ir_code;
  logic            ir_so, bsr_so;
  logic            sel_bsr;
  logic            byp_q, byp_en, byp_d;
  logic            tdo_q, tdo_d, oe_q, oe_d;

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
  );

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
    .ir_so(ir_so), .ir_code(ir_code)
  );

  assign sel_bsr     = (ir_code == OP_EXTEST) || (ir_code == OP_SAMPLE);
  assign mode_extest = (ir_code == OP_EXTEST);
  assign mode_clamp  = (ir_code == OP_CLAMP);
  assign mode_highz  = (ir_code == OP_HIGHZ);

  tap_bsr #(.LEN(BSR_LEN)) u_bsr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .sel(sel_bsr), .state(state),
    .pin_in(pin_in), .so(bsr_so), .drive(bsr_drive)
  );

  assign byp_en = !sel_bsr && ((state == ST_CAPDR) || (state == ST_SHDR));
  assign byp_d  = (state == ST_SHDR) ? tdi : 1'b0;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  always_comb begin
    oe_d  = (state == ST_SHIR) || (state == ST_SHDR);
    tdo_d = tdo_q;
    if (state == ST_SHIR)      tdo_d = ir_so;
    else if (state == ST_SHDR) tdo_d = sel_bsr ? bsr_so : byp_q;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      oe_q  <= oe_d;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

  // R10
  bypass_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!sel_bsr && state == ST_CAPDR) |=> (byp_q == 1'b0));
endmodule

// File: tb/jtag_tap_tb_top.sv
module jtag_tap_tb_top;
  localparam int unsigned BL = 8;

  logic          tck = 1'b0;
  logic          trst_n, tms, tdi;
  logic          tdo, tdo_oe;
  logic [BL-1:0] pin_in, bsr_drive;
  logic          mode_extest, mode_clamp, mode_highz;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] pre_upd_modes;

  // per code: {extest, clamp, highz, boundary selected}
  localparam logic [3:0] VEC [8] = '{
    4'b1001, 4'b0001, 4'b0000, 4'b0000,
    4'b0000, 4'b0010, 4'b0100, 4'b0000
  };

  jtag_tap #(.BSR_LEN(BL)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .pin_in(pin_in), .bsr_drive(bsr_drive),
    .mode_extest(mode_extest), .mode_clamp(mode_clamp), .mode_highz(mode_highz)
  );

  always #5 tck = ~tck;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic scan_ir(input logic [2:0] code, output logic [2:0] dout);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 3; i++) begin
      dout[i] = tdo;
      step(i == 2, code[i]);
    end
    pre_upd_modes = {mode_extest, mode_clamp, mode_highz};
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input logic [BL-1:0] din, output logic [BL-1:0] dout);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < BL; i++) begin
      dout[i] = tdo;
      step(i == BL - 1, din[i]);
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [2:0]    irout;
    logic [BL-1:0] dout, din, held, exp_out;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; pin_in = '0;
    #23;
    // R2 reset state
    check("R2 modes", {mode_extest, mode_clamp, mode_highz}, 3'b000);
    check("R2 oe", tdo_oe, 1'b0);
    check("R2 drive", bsr_drive, '0);
    @(negedge tck); #1 trst_n = 1'b1;
    step(0, 0);

    // R3: TDO moves only on the falling edge
    step(1, 0); step(0, 0); step(0, 0);
    check("R3 oe in shift", tdo_oe, 1'b1);
    check("R10 bypass capture", tdo, 1'b0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    check("R3 tdo held past rising edge", tdo, 1'b0);
    @(negedge tck); #1;
    check("R3 tdo after falling edge", tdo, 1'b1);
    step(1, 0);
    check("R3 oe off in Exit1", tdo_oe, 1'b0);
    step(1, 0); step(0, 0);

    // R5: new code shifted in is not active before Update-IR
    scan_ir(3'b000, irout);
    check("R5 no change before update", pre_upd_modes, 3'b000);
    check("R6 extest after update", mode_extest, 1'b1);

    // R1: five TMS highs from Shift-DR reach reset, IR back to BYPASS
    step(1, 0); step(0, 0); step(0, 0);
    for (int k = 0; k < 5; k++) step(1, 0);
    check("R1 five highs reset", {mode_extest, mode_clamp, mode_highz}, 3'b000);
    check("R1 oe idle", tdo_oe, 1'b0);
    step(0, 0);

    // vector walk over all codes
    for (int c = 0; c < 8; c++) begin
      string rq;
      rq = (c == 0) ? "R6" : (c == 1) ? "R7" : (c == 5) ? "R8" :
           (c == 6) ? "R9" : "R10";
      scan_ir(3'(c), irout);
      check("R4 ir capture", irout, 3'b001);
      check(rq, {mode_extest, mode_clamp, mode_highz}, VEC[c][3:1]);
      pin_in = 8'h5A ^ 8'(c * 19);
      din    = 8'hC3 + 8'(c * 41);
      held   = bsr_drive;
      scan_dr(din, dout);
      exp_out = VEC[c][0] ? pin_in : {din[BL-2:0], 1'b0};
      check({rq, " R11 dr out"}, dout, exp_out);
      check({rq, " R11 drive"}, bsr_drive, VEC[c][0] ? din : held);
      check("R3 oe after scan", tdo_oe, 1'b0);
    end

    // R2: asynchronous reset in the middle of operation
    scan_ir(3'b000, irout);
    check("R6 extest reload", mode_extest, 1'b1);
    trst_n = 1'b0;
    #2;
    check("R2 async modes", {mode_extest, mode_clamp, mode_highz}, 3'b000);
    check("R2 async drive", bsr_drive, '0);
    @(negedge tck); #1 trst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule